// File: doc/BRIEF.md
# Scan-Chain Identification Stream Parser

This block turns the serial data captured on the test data output during a data-register scan taken straight after test-logic-reset into one record per device on the chain. Bits arrive least significant first, one per cycle in which `bit_valid` is high. Each device field starts with a marker bit. A leading 1 opens a 32-bit identification word, and that first bit is the word's bit 0. A leading 0 is a device in bypass, which occupies exactly one bit.

For each device the parser emits a one-cycle record holding either the assembled word or a bypass flag, together with the device's position on the chain. A 32-bit word of all ones marks the end of the chain and ends parsing successfully, and so does an end-of-stream strobe that falls between two fields. Two conditions stop parsing with a fault: a word whose manufacturer field is reserved, and a stream that ends partway through a word.

The block keeps a running device count that saturates at eight. The first eight records are also written into a small record array that can be read back by position. The host fills the scan with all-ones input sized for at most eight devices, which is 256 bits. Parsing starts at reset and runs once; a new parse needs a new reset.

Top module: `idcode_chain_parser`

## Requirements
- R1: After reset, `rec_valid`, `done` and `fault` are 0, `fault_code` is 2'b00 and `tap_count` is 0.
- R2: A field whose first bit is 0 produces a bypass record one clock after that bit: `rec_valid`=1, `rec_bypass`=1, `rec_code`=0, and `rec_index` equal to the device count before the record. Parsing then expects a new field.
- R3: A field whose first bit is 1 is assembled together with the next 31 bits, least significant first, into a 32-bit word. If the word is valid, a record with `rec_bypass`=0 and `rec_code` equal to the word appears one clock after the 32nd bit.
- R4: An assembled word of all ones produces no record. One clock after its 32nd bit, `done` goes to 1 and `tap_count` keeps its value.
- R5: A word whose manufacturer field, bits 11 down to 1, equals 0 or 127 produces no record. One clock after its 32nd bit, `fault` goes to 1 with `fault_code`=2'b10.
- R6: A `stream_end` strobe while a word is only partly assembled sets `fault` to 1 with `fault_code`=2'b01 one clock later.
- R7: A `stream_end` strobe between fields sets `done` to 1 one clock later, with `fault_code`=2'b00 and `tap_count` equal to the number of records emitted so far.
- R8: Once `done` or `fault` is set, further bits and strobes produce no record and change neither `tap_count`, `done`, `fault` nor `fault_code` until reset.
- R9: When `bit_valid` and `stream_end` are high in the same cycle, the bit is processed and the strobe is ignored.
- R10: `tap_count` saturates at 8. A record beyond the eighth carries `rec_index`=7 and is not written to the record array.
- R11: One clock after `rd_index` is applied, `rd_bypass` and `rd_code` show the record that was stored at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts parsing |
| bit_valid | input | 1 | A captured bit is present on `bit_data` |
| bit_data | input | 1 | Captured bit, least significant first |
| stream_end | input | 1 | Strobe: no more captured bits follow |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_bypass | output | 1 | Record is a bypass device |
| rec_code | output | 32 | Identification word of the record (0 for bypass) |
| rec_index | output | 3 | Chain position of the record |
| tap_count | output | 4 | Records so far, saturating at 8 |
| done | output | 1 | Parsing ended successfully |
| fault | output | 1 | Parsing stopped on an error |
| fault_code | output | 2 | 00 none, 01 truncated word, 10 reserved manufacturer |
| rd_index | input | 3 | Record array read position |
| rd_bypass | output | 1 | Bypass flag of the stored record |
| rd_code | output | 32 | Word of the stored record |

## Verification
Every record, and every change to `done`, `fault`, `fault_code` and `tap_count`, is due exactly one clock after the edge that takes the deciding bit or strobe. Array read data is due one clock after `rd_index` is applied. The driver holds each input for one edge and reads status 2 ns after the next edge. The scoreboard monitor pops the expected record on each falling edge where `rec_valid` is high, so a record that comes early, late or unasked for is caught in the cycle it appears.

// File: rtl/idc_pkg.sv
package idc_pkg;

  typedef enum logic [1:0] {
    ST_FIELD = 2'd0,
    ST_CODE  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } parse_state_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_TRUNC   = 2'b01,
    FLT_BADCODE = 2'b10
  } fault_t;

  localparam int MFR_LO   = 1;
  localparam int MFR_HI   = 11;
  localparam int MFR_RSVD = 127;

  // Manufacturer field must be neither zero nor the reserved value
  function automatic logic mfr_ok(input logic [31:0] w);
    logic [MFR_HI-MFR_LO:0] f;
    f = w[MFR_HI:MFR_LO];
    return w[0] && (f != '0) && (f != (MFR_HI-MFR_LO+1)'(MFR_RSVD));
  endfunction

endpackage

// File: rtl/idc_bit_assembler.sv
module idc_bit_assembler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] word_next,
  output logic         last
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  word_q;
  logic [CW-1:0] held_q;

  // Incoming bits enter at the top and move down; after W bits the first is bit 0
  assign word_next = {bit_in, word_q[W-1:1]};
  assign last      = (held_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      held_q <= '0;
    end else if (load) begin
      word_q <= {bit_in, {(W-1){1'b0}}};
      held_q <= CW'(1);
    end else if (shift) begin
      word_q <= word_next;
      held_q <= last ? '0 : held_q + CW'(1);
    end
  end

  // R3
  held_range_chk: assert property (@(posedge clk) disable iff (rst)
    held_q < CW'(W));

  // R3
  load_empty_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (held_q == '0));

endmodule

// File: rtl/idc_record_store.sv
module idc_record_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 33
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array with registered read, no reset on contents
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/idc_parse_ctrl.sv
module idc_parse_ctrl
  import idc_pkg::*;
#(
  parameter int W        = 32,
  parameter int MAX_TAPS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bit_valid,
  input  logic                        bit_data,
  input  logic                        stream_end,
  input  logic                        last,
  input  logic [W-1:0]                word_next,
  output logic                        load,
  output logic                        shift,
  output logic                        rec_valid,
  output logic                        rec_bypass,
  output logic [W-1:0]                rec_code,
  output logic [$clog2(MAX_TAPS)-1:0] rec_index,
  output logic [$clog2(MAX_TAPS+1)-1:0] tap_count,
  output logic                        done,
  output logic                        fault,
  output logic [1:0]                  fault_code,
  output logic                        wr_en,
  output logic [$clog2(MAX_TAPS)-1:0] wr_addr,
  output logic [W:0]                  wr_data
);
  localparam int IW = $clog2(MAX_TAPS);
  localparam int CW = $clog2(MAX_TAPS + 1);

  parse_state_t st_q, st_n;
  fault_t       flt_n;
  logic         emit, emit_byp;
  logic [W-1:0] emit_code;
  logic         full;
  logic [IW-1:0] idx_now;

  assign full    = (tap_count >= CW'(MAX_TAPS));
  assign idx_now = full ? IW'(MAX_TAPS - 1) : tap_count[IW-1:0];

  always_comb begin
    st_n      = st_q;
    flt_n     = fault_t'(fault_code);
    load      = 1'b0;
    shift     = 1'b0;
    emit      = 1'b0;
    emit_byp  = 1'b0;
    emit_code = '0;
    case (st_q)
      ST_FIELD: begin
        if (bit_valid) begin
          if (bit_data) begin
            load = 1'b1;
            st_n = ST_CODE;
          end else begin
            emit     = 1'b1;
            emit_byp = 1'b1;
          end
        end else if (stream_end) begin
          st_n = ST_DONE;
        end
      end
      ST_CODE: begin
        if (bit_valid) begin
          shift = 1'b1;
          if (last) begin
            if (&word_next) begin
              st_n = ST_DONE;
            end else if (mfr_ok(word_next)) begin
              emit      = 1'b1;
              emit_code = word_next;
              st_n      = ST_FIELD;
            end else begin
              st_n  = ST_FAULT;
              flt_n = FLT_BADCODE;
            end
          end
        end else if (stream_end) begin
          st_n  = ST_FAULT;
          flt_n = FLT_TRUNC;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_FIELD;
      rec_valid  <= 1'b0;
      rec_bypass <= 1'b0;
      rec_code   <= '0;
      rec_index  <= '0;
      tap_count  <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      st_q       <= st_n;
      rec_valid  <= emit;
      rec_bypass <= emit_byp;
      rec_code   <= emit_code;
      if (emit) begin
        rec_index <= idx_now;
        if (!full) tap_count <= tap_count + CW'(1);
      end
      done       <= (st_n == ST_DONE);
      fault      <= (st_n == ST_FAULT);
      fault_code <= flt_n;
    end
  end

  assign wr_en   = emit && !full;
  assign wr_addr = tap_count[IW-1:0];
  assign wr_data = {emit_byp, emit_code};

  // R1
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(tap_count) && !rec_valid);

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault && $stable(fault_code) && !rec_valid);

  // R10
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    tap_count <= CW'(MAX_TAPS));

  // R2
  bypass_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_bypass) |-> (rec_code == '0));

  // R4
  no_allones_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_bypass) |-> (rec_code[0] && (rec_code != '1)));

endmodule

// File: rtl/idcode_chain_parser.sv
module idcode_chain_parser #(
  parameter int CODE_W   = 32,
  parameter int MAX_TAPS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bit_valid,
  input  logic                          bit_data,
  input  logic                          stream_end,
  output logic                          rec_valid,
  output logic                          rec_bypass,
  output logic [CODE_W-1:0]             rec_code,
  output logic [$clog2(MAX_TAPS)-1:0]   rec_index,
  output logic [$clog2(MAX_TAPS+1)-1:0] tap_count,
  output logic                          done,
  output logic                          fault,
  output logic [1:0]                    fault_code,
  input  logic [$clog2(MAX_TAPS)-1:0]   rd_index,
  output logic                          rd_bypass,
  output logic [CODE_W-1:0]             rd_code
);
  localparam int IW = $clog2(MAX_TAPS);
  localparam int DW = CODE_W + 1;

  logic              load, shift, last;
  logic [CODE_W-1:0] word_next;
  logic              wr_en;
  logic [IW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data, rd_data;

  idc_bit_assembler #(.W(CODE_W)) asm_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .shift     (shift),
    .bit_in    (bit_data),
    .word_next (word_next),
    .last      (last)
  );

  idc_parse_ctrl #(.W(CODE_W), .MAX_TAPS(MAX_TAPS)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .stream_end (stream_end),
    .last       (last),
    .word_next  (word_next),
    .load       (load),
    .shift      (shift),
    .rec_valid  (rec_valid),
    .rec_bypass (rec_bypass),
    .rec_code   (rec_code),
    .rec_index  (rec_index),
    .tap_count  (tap_count),
    .done       (done),
    .fault      (fault),
    .fault_code (fault_code),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  idc_record_store #(.DEPTH(MAX_TAPS), .DW(DW)) store_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_index),
    .rdata (rd_data)
  );

  assign rd_bypass = rd_data[DW-1];
  assign rd_code   = rd_data[CODE_W-1:0];

endmodule

// File: tb/idcode_chain_parser_tb_top.sv
module idcode_chain_parser_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        stream_end = 1'b0;
  logic        rec_valid, rec_bypass;
  logic [31:0] rec_code;
  logic [2:0]  rec_index;
  logic [3:0]  tap_count;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic [2:0]  rd_index = 3'd0;
  logic        rd_bypass;
  logic [31:0] rd_code;

  int checks = 0;
  int failures = 0;
  int m_count = 0;
  bit finished = 1'b0;
  logic [35:0] expq [$];

  always #10 clk = ~clk;

  idcode_chain_parser dut_i (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
    .stream_end(stream_end), .rec_valid(rec_valid), .rec_bypass(rec_bypass),
    .rec_code(rec_code), .rec_index(rec_index), .tap_count(tap_count),
    .done(done), .fault(fault), .fault_code(fault_code),
    .rd_index(rd_index), .rd_bypass(rd_bypass), .rd_code(rd_code)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit code_ok(input logic [31:0] w);
    return w[0] && (w[11:1] != 11'd0) && (w[11:1] != 11'd127);
  endfunction

  task automatic expect_rec(input bit byp, input logic [31:0] code);
    logic [2:0] idx;
    idx = (m_count >= 8) ? 3'd7 : 3'(m_count);
    expq.push_back({byp, code, idx});
    if (m_count < 8) m_count++;
  endtask

  // Monitor: pops expected records as the design produces them
  always @(negedge clk) begin
    if (!rst && rec_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R8 actual=unexpected record %0h expected=none", rec_code);
      end else begin
        logic [35:0] e;
        e = expq.pop_front();
        if ({rec_bypass, rec_code, rec_index} !== e) begin
          failures++;
          $display("FAIL R2/R3 actual=%0h expected=%0h",
                   {rec_bypass, rec_code, rec_index}, e);
        end
      end
    end
  end

  task automatic put_bit(input bit b);
    bit_valid = 1'b1; bit_data = b;
    @(posedge clk); #2;
    bit_valid = 1'b0;
  endtask

  task automatic put_bit_end(input bit b);
    bit_valid = 1'b1; bit_data = b; stream_end = 1'b1;
    @(posedge clk); #2;
    bit_valid = 1'b0; stream_end = 1'b0;
  endtask

  task automatic put_end();
    stream_end = 1'b1;
    @(posedge clk); #2;
    stream_end = 1'b0;
  endtask

  task automatic bypass_tap();
    expect_rec(1'b1, 32'd0);
    put_bit(1'b0);
  endtask

  task automatic code_tap(input logic [31:0] w);
    if (w != 32'hFFFF_FFFF && code_ok(w)) expect_rec(1'b0, w);
    for (int i = 0; i < 32; i++) put_bit(w[i]);
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_valid = 1'b0; stream_end = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    m_count = 0;
  endtask

  task automatic drain(input string req);
    repeat (2) @(posedge clk);
    #2;
    check(req, 36'(expq.size()), 36'd0);
    expq.delete();
  endtask

  task automatic read_back(input logic [2:0] idx, input bit byp, input logic [31:0] code);
    rd_index = idx;
    @(posedge clk); #2;
    check("R11", {3'd0, rd_bypass, rd_code}, {3'd0, byp, code});
  endtask

  initial begin
    // Watchdog
    #4000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1", {30'd0, rec_valid, done, fault, fault_code, 1'b0}, 36'd0);
    check("R1", 36'(tap_count), 36'd0);

    // Mixed chain: code, bypass, code, then all-ones word
    code_tap(32'h4BA0_0477);
    bypass_tap();
    code_tap(32'h0643_3041);
    code_tap(32'hFFFF_FFFF);
    check("R4", {34'd0, done, fault}, {34'd0, 1'b1, 1'b0});
    check("R4", 36'(tap_count), 36'd3);
    // R8: bits and strobes after done are ignored
    put_bit(1'b0);
    code_tap(32'hFFFF_FFFF);
    put_end();
    check("R8", {30'd0, tap_count, done, fault}, {30'd0, 4'd3, 1'b1, 1'b0});
    drain("R3");
    // R11: readback
    read_back(3'd0, 1'b0, 32'h4BA0_0477);
    read_back(3'd1, 1'b1, 32'd0);
    read_back(3'd2, 1'b0, 32'h0643_3041);

    // R5: manufacturer field zero
    do_reset();
    code_tap(32'h0000_0001);
    check("R5", {32'd0, fault, done, fault_code}, {32'd0, 1'b1, 1'b0, 2'b10});
    check("R5", 36'(tap_count), 36'd0);
    put_bit(1'b0);
    put_end();
    check("R8", {30'd0, tap_count, fault, fault_code}, {30'd0, 4'd0, 1'b1, 2'b10});
    drain("R5");

    // R5: manufacturer field 127
    do_reset();
    bypass_tap();
    code_tap(32'h0000_00FF);
    check("R5", {32'd0, fault, done, fault_code}, {32'd0, 1'b1, 1'b0, 2'b10});
    drain("R5");

    // R6: truncated word
    do_reset();
    put_bit(1'b1);
    for (int i = 0; i < 9; i++) put_bit(1'b0);
    check("R6", {34'd0, fault, done}, {34'd0, 1'b0, 1'b0});
    put_end();
    check("R6", {32'd0, fault, done, fault_code}, {32'd0, 1'b1, 1'b0, 2'b01});
    drain("R6");

    // R7: end between fields
    do_reset();
    bypass_tap();
    bypass_tap();
    put_end();
    check("R7", {30'd0, tap_count, done, fault}, {30'd0, 4'd2, 1'b1, 1'b0});
    check("R7", 36'(fault_code), 36'd0);
    drain("R7");

    // R9: bit wins over simultaneous end
    do_reset();
    expect_rec(1'b1, 32'd0);
    put_bit_end(1'b0);
    check("R9", {34'd0, done, fault}, 36'd0);
    check("R9", 36'(tap_count), 36'd1);
    put_end();
    check("R9", {35'd0, done}, 36'd1);
    drain("R9");

    // R10: saturation
    do_reset();
    for (int i = 0; i < 9; i++) bypass_tap();
    code_tap(32'h1234_5677);
    put_end();
    check("R10", {31'd0, tap_count, done}, {31'd0, 4'd8, 1'b1});
    drain("R10");
    read_back(3'd7, 1'b1, 32'd0);
    read_back(3'd0, 1'b1, 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule